// File: doc/BRIEF.md
# Quarter-Rate Input Mixer

This block sits in front of a decimating filter chain. It multiplies every accepted input sample by a mix factor, either to scale the stream or to move its spectrum. Two sources feed the factor. In one, an internal four-entry sequencer produces the values of a sinusoid at one quarter of the sample rate, in either sine or cosine phase. In the other, a factor is loaded serially from outside over two pins: a bit pin and a frame-start pin.

Each product is rounded back to the sample width and saturated, and then registered. The sequencer moves to its next entry only when a sample is accepted in internal mode. Any change of the source select returns it to its first entry. A serially loaded factor replaces the active one in a single step, once its last bit has arrived.

Top module: `quad_mixer`

## Requirements
- R1: While `rst_n` is low and on release of reset, `out_valid` and `out_data` are 0, the sequencer is at entry 0, and the external factor is 0, so a sample in external mode then yields 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `smp_valid` high. `out_data` then holds round(sample × factor / 2^15), where the factor is a signed Q1.15 value.
- R3: With `src_ext`=0 and `rom_cos`=0, successive accepted samples are multiplied by 0, +1, 0, -1, repeating from entry 0.
- R4: With `src_ext`=0 and `rom_cos`=1, successive accepted samples are multiplied by +1, 0, -1, 0, repeating from entry 0. Multiplying by +1 returns the sample unchanged.
- R5: The sequencer does not advance in cycles without `smp_valid`.
- R6: Any change of `src_ext` returns the sequencer to entry 0. A sample accepted in the cycle of the change already uses entry 0.
- R7: The external factor is 16 bits in two's complement, shifted in MSB first on `mix_sd`, one bit per clock. `mix_sync` is high for one clock together with the first bit.
- R8: A factor that is being shifted in becomes active only after its 16th bit. A sample in any cycle of the frame, the cycle of the last bit included, uses the previous factor. A sample in the next cycle uses the new one.
- R9: A `mix_sync` pulse in the middle of a frame discards the partial frame and starts a new one.
- R10: Rounding adds 2^14 to the full product and then shifts it arithmetically right by 15, which rounds halves toward +infinity. For example, 3×0.5 gives 2 and -3×0.5 gives -1.
- R11: Results above the sample range saturate to +(2^23-1). The only such case is -2^23 multiplied by -1, from either source.
- R12: In cycles without an accepted sample, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_ext | input | 1 | Factor source: 0 internal sequencer, 1 serially loaded factor |
| rom_cos | input | 1 | Sequencer phase: 0 sine, 1 cosine |
| smp_valid | input | 1 | Input sample is present this cycle |
| smp_data | input | 24 | Signed input sample |
| mix_sd | input | 1 | Serial factor bit, MSB first |
| mix_sync | input | 1 | Frame start, high together with the first factor bit |
| out_valid | output | 1 | Mixed sample is present |
| out_data | output | 24 | Signed, rounded and saturated mixed sample |

## Verification
The hardest case to produce from the ports is a sample that arrives while a factor is half shifted in, and in particular one that lands on the very cycle of the last bit. That sample must still see the old factor, and only the next one sees the new factor. The bench drives the bit stream and the sample strobe from one loop, so it can place samples at an exact bit index of a frame. A second hard case is reaching the -1 sequencer entry with the most negative sample. The bench gets there by toggling the source select to restart the cosine sequence and then counting accepted samples up to entry 2.

// File: rtl/qm_pkg.sv
package qm_pkg;

   typedef enum logic {
      SRC_ROM = 1'b0,
      SRC_EXT = 1'b1
   } mix_src_e;

   typedef logic [1:0] qm_phase_t;

   // sign of a quarter-rate sine at entry p: 0, +1, 0, -1
   function automatic logic signed [1:0] qm_sine_sign(input qm_phase_t p);
      case (p)
         2'd1:    return 2'sb01;
         2'd3:    return 2'sb11;
         default: return 2'sb00;
      endcase
   endfunction

endpackage

// File: rtl/qm_rom_seq.sv
module qm_rom_seq
   import qm_pkg::*;
#(
   parameter int MIX_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  src_ext,
   input  logic                  cos_sel,
   input  logic                  adv,
   output qm_phase_t             phase,
   output logic signed [MIX_W:0] rom_fac
);
   localparam logic signed [MIX_W:0] ONE = {2'b01, {(MIX_W-1){1'b0}}};

   logic      src_q;
   qm_phase_t ph_eff;
   qm_phase_t ph_look;

   assign ph_eff  = (src_ext != src_q) ? 2'd0 : phase;
   assign ph_look = ph_eff + {1'b0, cos_sel};

   always_comb begin
      case (qm_sine_sign(ph_look))
         2'sb01:  rom_fac = ONE;
         2'sb11:  rom_fac = -ONE;
         default: rom_fac = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         phase <= 2'd0;
      end else begin
         src_q <= src_ext;
         phase <= adv ? ph_eff + 2'd1 : ph_eff;
      end
   end
endmodule

// File: rtl/qm_serial_loader.sv
module qm_serial_loader #(
   parameter int MIX_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ser_d,
   input  logic                    ser_sync,
   output logic signed [MIX_W-1:0] fac
);
   localparam int CNT_W = $clog2(MIX_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MIX_W - 1);

   logic [MIX_W-2:0] sh;
   logic [CNT_W-1:0] cnt;
   logic             busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         cnt  <= '0;
         busy <= 1'b0;
         fac  <= '0;
      end else if (ser_sync) begin
         sh   <= {sh[MIX_W-3:0], ser_d};
         cnt  <= CNT_W'(1);
         busy <= 1'b1;
      end else if (busy) begin
         sh <= {sh[MIX_W-3:0], ser_d};
         if (cnt == LAST) begin
            fac  <= {sh, ser_d};
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/qm_mult_round.sv
module qm_mult_round #(
   parameter int DATA_W   = 24,
   parameter int MIX_W    = 16,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   input  logic signed [MIX_W:0]    fac,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data
);
   localparam int PW = DATA_W + MIX_W + 1;
   localparam int SH = MIX_W - 1;
   localparam logic signed [PW-1:0] MAXV = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [PW-1:0] MINV = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

   logic signed [PW-1:0]     a_ext, b_ext, prod, biased, scaled;
   logic signed [DATA_W-1:0] clipped;

   assign a_ext = {{(PW-DATA_W){in_data[DATA_W-1]}}, in_data};
   assign b_ext = {{(PW-MIX_W-1){fac[MIX_W]}}, fac};
   assign prod  = a_ext * b_ext;

   generate
      if (ROUND_EN) begin : g_round
         assign biased = prod + (PW'(1) << (SH - 1));
      end else begin : g_trunc
         assign biased = prod;
      end
   endgenerate

   assign scaled = biased >>> SH;

   always_comb begin
      if (scaled > MAXV)      clipped = MAXV[DATA_W-1:0];
      else if (scaled < MINV) clipped = MINV[DATA_W-1:0];
      else                    clipped = scaled[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= clipped;
      end
   end
endmodule

// File: rtl/quad_mixer.sv
module quad_mixer
   import qm_pkg::*;
#(
   parameter int DATA_W   = 24,
   parameter int MIX_W    = 16,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_ext,
   input  logic              rom_cos,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              mix_sd,
   input  logic              mix_sync,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("quad_mixer: DATA_W must be at least 8");
      end
      if (MIX_W < 4) begin : g_bad_mix_w
         $error("quad_mixer: MIX_W must be at least 4");
      end
   endgenerate

   mix_src_e                 src_sel;
   qm_phase_t                rom_phase;
   logic signed [MIX_W:0]    rom_fac;
   logic signed [MIX_W-1:0]  ext_fac;
   logic signed [MIX_W:0]    mix_now;
   logic signed [DATA_W-1:0] res;

   assign src_sel = mix_src_e'(src_ext);

   qm_rom_seq #(.MIX_W(MIX_W)) u_rom (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_ext (src_ext),
      .cos_sel (rom_cos),
      .adv     (smp_valid && (src_sel == SRC_ROM)),
      .phase   (rom_phase),
      .rom_fac (rom_fac)
   );

   qm_serial_loader #(.MIX_W(MIX_W)) u_ld (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_d    (mix_sd),
      .ser_sync (mix_sync),
      .fac      (ext_fac)
   );

   assign mix_now = (src_sel == SRC_EXT) ? {ext_fac[MIX_W-1], ext_fac} : rom_fac;

   qm_mult_round #(.DATA_W(DATA_W), .MIX_W(MIX_W), .ROUND_EN(ROUND_EN)) u_mul (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (smp_valid),
      .in_data   (smp_data),
      .fac       (mix_now),
      .out_valid (out_valid),
      .out_data  (res)
   );

   assign out_data = res;
endmodule

// File: rtl/quad_mixer_chk.sv
module quad_mixer_chk #(
   parameter int DATA_W = 24,
   parameter int MIX_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              src_ext,
   input logic              smp_valid,
   input logic [DATA_W-1:0] smp_data,
   input logic              mix_sync,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic [1:0]        rom_phase,
   input logic [MIX_W-1:0]  ext_fac,
   input logic [MIX_W:0]    mix_now
);
   localparam logic [DATA_W-1:0] DMAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] DMIN = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [MIX_W:0]    FMIN = {2'b11, {(MIX_W-1){1'b0}}};

   function automatic logic [DATA_W-1:0] neg_sat(input logic [DATA_W-1:0] d);
      return (d == DMIN) ? DMAX : (~d + 1'b1);
   endfunction

   // R2
   valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> out_valid);
   // R2
   valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> !out_valid);
   // R12
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(out_data));
   // R3
   rom_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !src_ext) |=> (out_data == '0 || out_data == $past(smp_data)
                                   || out_data == neg_sat($past(smp_data))));
   // R6
   phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ext != $past(src_ext) && !smp_valid) |=> rom_phase == 2'd0);
   // R8
   sync_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mix_sync |=> $stable(ext_fac));
   // R11
   saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_data == DMIN && mix_now == FMIN) |=> out_data == DMAX);
endmodule

bind quad_mixer quad_mixer_chk #(.DATA_W(DATA_W), .MIX_W(MIX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_ext   (src_ext),
   .smp_valid (smp_valid),
   .smp_data  (smp_data),
   .mix_sync  (mix_sync),
   .out_valid (out_valid),
   .out_data  (out_data),
   .rom_phase (rom_phase),
   .ext_fac   (ext_fac),
   .mix_now   (mix_now)
);

// File: tb/quad_mixer_test.sv
module quad_mixer_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        src_ext, rom_cos, smp_valid, mix_sd, mix_sync;
   logic [23:0] smp_data;
   logic        out_valid;
   logic [23:0] out_data;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   localparam int NV = 12;
   localparam logic [15:0] V_FAC [NV] = '{16'h4000, 16'h4000, 16'h4000, 16'h7FFF,
      16'h8000, 16'h8000, 16'h8000, 16'hC000, 16'h0001, 16'h0000, 16'h2000, 16'hFFFF};
   localparam logic signed [23:0] V_DIN [NV] = '{24'sd1000, 24'sd3, -24'sd3, 24'sd8388607,
      24'h800000, 24'sd5, 24'sd8388607, 24'sd7, 24'sd16384, 24'h800000, 24'h800000, 24'sd16385};
   localparam logic signed [23:0] V_EXP [NV] = '{24'sd500, 24'sd2, -24'sd1, 24'sd8388351,
      24'sd8388607, -24'sd5, -24'sd8388607, -24'sd3, 24'sd1, 24'sd0, -24'sd2097152, -24'sd1};

   quad_mixer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_ext   (src_ext),
      .rom_cos   (rom_cos),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .mix_sd    (mix_sd),
      .mix_sync  (mix_sync),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", req, $signed(act), $signed(exp));
      end
   endtask

   // called just after a falling edge; returns one falling edge later
   task automatic send(input logic [23:0] d);
      smp_valid = 1'b1;
      smp_data  = d;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic load_fac(input logic [15:0] f);
      for (int b = 15; b >= 0; b--) begin
         mix_sync = (b == 15);
         mix_sd   = f[b];
         @(negedge clk);
      end
      mix_sync = 1'b0;
      mix_sd   = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; src_ext = 1'b1; rom_cos = 1'b0; smp_valid = 1'b0;
      smp_data = '0; mix_sd = 1'b0; mix_sync = 1'b0;
      idle(3);
      // R1: outputs cleared during reset
      chk("R1", {23'd0, out_valid}, 24'd0);
      chk("R1", out_data, 24'd0);
      rst_n = 1'b1;
      idle(1);
      // R1: external factor is zero after reset
      send(24'sd12345);
      chk("R1", out_data, 24'd0);

      // R3 sine sequence, R5 idle cycles do not advance
      src_ext = 1'b0;
      idle(1);
      send(24'sd100); chk("R3", out_data, 24'd0);
      idle(2);
      send(24'sd100); chk("R5", out_data, 24'sd100);
      send(24'sd100); chk("R3", out_data, 24'd0);
      send(24'sd100); chk("R3", out_data, -24'sd100);
      send(24'sd100); chk("R3", out_data, 24'd0);

      // R6 source toggle restarts at entry 0, R4 cosine, R11 via sequencer
      rom_cos = 1'b1;
      src_ext = 1'b1;
      idle(2);
      src_ext = 1'b0;
      idle(1);
      send(24'sd7);      chk("R6", out_data, 24'sd7);
      send(24'h800000);  chk("R4", out_data, 24'd0);
      send(24'h800000);  chk("R11", out_data, 24'sd8388607);
      send(24'sd9);      chk("R4", out_data, 24'd0);
      send(24'sd11);     chk("R4", out_data, 24'sd11);

      // R6: change of source in the same cycle as a sample uses entry 0
      send(24'sd13);     chk("R4", out_data, 24'd0);
      src_ext = 1'b1; idle(1);
      src_ext = 1'b0;
      send(24'sd15);     chk("R6", out_data, 24'sd15);

      // vector table: R7 serial load, R10 rounding, R11 saturation, R12 hold
      src_ext = 1'b1;
      for (int i = 0; i < NV; i++) begin
         load_fac(V_FAC[i]);
         send(V_DIN[i]);
         if (i == 4)                           chk("R11", out_data, V_EXP[i]);
         else if (i == 1 || i == 2 || i == 11) chk("R10", out_data, V_EXP[i]);
         else                                  chk("R7", out_data, V_EXP[i]);
         chk("R2", {23'd0, out_valid}, 24'd1);
         idle(1);
         chk("R2", {23'd0, out_valid}, 24'd0);
         chk("R12", out_data, V_EXP[i]);
      end

      // R8: samples during a frame, including the last bit, use the old factor
      load_fac(16'h4000);
      for (int b = 15; b >= 0; b--) begin
         mix_sync = (b == 15);
         mix_sd   = (b == 15);
         smp_valid = (b == 8 || b == 0);
         smp_data  = 24'sd10;
         @(negedge clk);
         if (b == 8 || b == 0) chk("R8", out_data, 24'sd5);
      end
      mix_sync = 1'b0; mix_sd = 1'b0; smp_valid = 1'b0;
      send(24'sd10); chk("R8", out_data, -24'sd10);

      // R9: a new sync mid-frame restarts the frame
      for (int b = 15; b >= 11; b--) begin
         mix_sync = (b == 15);
         mix_sd   = ((16'h1234 >> b) & 16'h1) != 0;
         @(negedge clk);
      end
      load_fac(16'h2000);
      send(24'sd100); chk("R9", out_data, 24'sd25);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule